// File: doc/BRIEF.md
# I2C Byte-Memory Slave Front End

This block lets an I2C master reach a 64K x 8 synchronous SRAM. It watches the bus lines in the system clock domain and finds START and STOP conditions. It shifts bytes in and out and drives the data line low only through an open-drain enable. The slave responds to a 7-bit bus address. The top bits of that address are a fixed code and the three low bits come from strap inputs. A write transfer carries a 16-bit word address, high byte first, and then any number of data bytes. A read transfer returns bytes from a persistent address pointer.

The pointer keeps its value between transfers. A read with no address phase therefore carries on where the last transfer stopped. A random read is a write of the two address bytes, then a repeated START, then the bus address with the read bit set. A write-protect input keeps data bytes out of the array. A busy input stands for a store or recall in progress: while it is high the slave does not acknowledge and makes no memory access.

Top module: `i2cmem_slave`

## Requirements
- R1: After reset the data-line enable is low, no memory access is issued and the address pointer is 0x0000.
- R2: The bus address byte is acknowledged only when its bits 7..4 equal the fixed code (default 4'b1010) and bits 3..1 equal the strap inputs. Otherwise the slave leaves the data line released and makes no memory access until the next START.
- R3: In a write transfer (bit 0 of the address byte = 0), the slave acknowledges the high and the low word-address bytes. Each data byte that follows is acknowledged and written to the pointer address.
- R4: The pointer advances by one after every data byte written or read, and it wraps from 0xFFFF to 0x0000.
- R5: A read transfer (bit 0 = 1) with no address phase returns first the byte at the current pointer, which is one past the last data byte transferred.
- R6: A random read (address bytes, then a repeated START, then a read address byte) returns the bytes from the new address onwards.
- R7: Read data goes out MSB first. After a master NACK the slave releases the data line, sends no further byte, and the next read continues at the following address.
- R8: While write-protect is high, data bytes are still acknowledged and the pointer still advances, but the array is not written.
- R9: While busy is high, the slave does not acknowledge the byte that is ending and issues no memory access.
- R10: The data-line enable changes only while the clock line is low, or on a START or STOP.
- R11: A START at any point abandons the transfer in progress. A word address that is not complete leaves the pointer unchanged.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock, much faster than the bus clock |
| rst | input | 1 | Synchronous active-high reset |
| scl_i | input | 1 | Bus clock line as sampled |
| sda_i | input | 1 | Bus data line as sampled (the resolved wire) |
| sda_oe | output | 1 | High pulls the data line low |
| strap_i | input | 3 | Board straps for the low bus-address bits |
| wp_i | input | 1 | Write protect: array writes blocked when high |
| busy_i | input | 1 | Store/recall in progress: no acknowledge, no access |
| mem_en | output | 1 | SRAM access strobe |
| mem_we | output | 1 | SRAM write enable |
| mem_addr | output | 16 | SRAM word address |
| mem_wdata | output | 8 | SRAM write data |
| mem_rdata | input | 8 | SRAM read data, valid the cycle after a read strobe |

## Verification
The bench uses the default parameters: a 16-bit address, the code 4'b1010, two synchronizer stages and the strap value 3'b101. With the full 16-bit address the master can load 0xFFFF directly, so the pointer wrap costs only two data bytes. Having both a matching strap value and the mismatching values 3'b011 and upper code 4'b1011 lets the bench exercise acknowledge and silence in the same run. The bus clock is stretched to 40 system clocks, which leaves room for the synchronizer delay and the one-cycle SRAM read before the next data bit is due.

// File: rtl/i2cmem_pkg.sv
package i2cmem_pkg;
  localparam int BYTE_W = 8;

  typedef enum logic [3:0] {
    ST_IDLE,
    ST_DEV,
    ST_AHI,
    ST_ALO,
    ST_WR,
    ST_ACKWAIT,
    ST_ACK,
    ST_RD,
    ST_RREL,
    ST_MACK
  } st_e;
endpackage

// File: rtl/i2cmem_line_sync.sv
module i2cmem_line_sync #(
  parameter int SYNC_N = 2
) (
  input  logic clk,
  input  logic rst,
  input  logic scl_i,
  input  logic sda_i,
  output logic scl_s,
  output logic sda_s,
  output logic scl_rise,
  output logic scl_fall,
  output logic start_det,
  output logic stop_det
);
  logic [SYNC_N-1:0] scl_pipe, sda_pipe;
  logic scl_q, sda_q;

  always_ff @(posedge clk) begin
    if (rst) begin
      scl_pipe <= '1;
      sda_pipe <= '1;
      scl_q    <= 1'b1;
      sda_q    <= 1'b1;
    end else begin
      scl_pipe <= {scl_pipe[SYNC_N-2:0], scl_i};
      sda_pipe <= {sda_pipe[SYNC_N-2:0], sda_i};
      scl_q    <= scl_pipe[SYNC_N-1];
      sda_q    <= sda_pipe[SYNC_N-1];
    end
  end

  assign scl_s     = scl_pipe[SYNC_N-1];
  assign sda_s     = sda_pipe[SYNC_N-1];
  assign scl_rise  = scl_s & ~scl_q;
  assign scl_fall  = ~scl_s & scl_q;
  assign start_det = scl_s & scl_q & sda_q & ~sda_s;
  assign stop_det  = scl_s & scl_q & ~sda_q & sda_s;
endmodule

// File: rtl/i2cmem_ptr.sv
module i2cmem_ptr #(
  parameter int ADDR_W = 16
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              ld_hi,
  input  logic              ld_lo,
  input  logic              inc,
  input  logic [7:0]        byte_i,
  output logic [ADDR_W-1:0] ptr_o
);
  localparam int HI_W = ADDR_W - 8;
  logic [HI_W-1:0] hi_q;

  always_ff @(posedge clk) begin
    if (rst) begin
      hi_q  <= '0;
      ptr_o <= '0;
    end else begin
      if (ld_hi) hi_q <= byte_i[HI_W-1:0];
      if (ld_lo)    ptr_o <= {hi_q, byte_i};
      else if (inc) ptr_o <= ptr_o + ADDR_W'(1);
    end
  end

  // R4: one step per transferred byte, wrapping at the top
  p_ptr_step_r4: assert property (@(posedge clk) disable iff (rst)
    $past(inc && !ld_lo) |-> (ptr_o == $past(ptr_o) + ADDR_W'(1)));
endmodule

// File: rtl/i2cmem_slave.sv
module i2cmem_slave
  import i2cmem_pkg::*;
#(
  parameter int               ADDR_W   = 16,
  parameter int               STRAP_W  = 3,
  parameter int               SYNC_N   = 2,
  parameter logic [6-STRAP_W:0] DEV_CODE = 4'b1010
) (
  input  logic               clk,
  input  logic               rst,
  input  logic               scl_i,
  input  logic               sda_i,
  output logic               sda_oe,
  input  logic [STRAP_W-1:0] strap_i,
  input  logic               wp_i,
  input  logic               busy_i,
  output logic               mem_en,
  output logic               mem_we,
  output logic [ADDR_W-1:0]  mem_addr,
  output logic [BYTE_W-1:0]  mem_wdata,
  input  logic [BYTE_W-1:0]  mem_rdata
);
  localparam int CNT_W = $clog2(BYTE_W);

  logic scl_s, sda_s, scl_rise, scl_fall, start_det, stop_det;
  st_e  state, ret;
  logic [CNT_W-1:0]  bitcnt;
  logic [BYTE_W-2:0] rx;
  logic [BYTE_W-1:0] tx, byte_in;
  logic ack_ok, rd_pend;
  logic dev_hit, rx_state, take, issue_rd, issue_wr, ld_hi, ld_lo, adv, ptr_inc;
  st_e  nxt;
  logic [ADDR_W-1:0] ptr;

  i2cmem_line_sync #(.SYNC_N(SYNC_N)) u_sync (
    .clk(clk), .rst(rst), .scl_i(scl_i), .sda_i(sda_i),
    .scl_s(scl_s), .sda_s(sda_s), .scl_rise(scl_rise), .scl_fall(scl_fall),
    .start_det(start_det), .stop_det(stop_det)
  );

  i2cmem_ptr #(.ADDR_W(ADDR_W)) u_ptr (
    .clk(clk), .rst(rst), .ld_hi(ld_hi), .ld_lo(ld_lo), .inc(ptr_inc),
    .byte_i(byte_in), .ptr_o(ptr)
  );

  always_comb begin
    byte_in  = {rx, sda_s};
    dev_hit  = (byte_in[7:1] == {DEV_CODE, strap_i});
    rx_state = (state == ST_DEV) || (state == ST_AHI) ||
               (state == ST_ALO) || (state == ST_WR);
    take     = 1'b0;
    nxt      = ST_IDLE;
    issue_rd = 1'b0;
    issue_wr = 1'b0;
    ld_hi    = 1'b0;
    ld_lo    = 1'b0;
    adv      = 1'b0;
    case (state)
      ST_DEV: begin
        take     = dev_hit && !busy_i;
        nxt      = byte_in[0] ? ST_RD : ST_AHI;
        issue_rd = scl_rise && (bitcnt == CNT_W'(BYTE_W-1)) && take && byte_in[0];
      end
      ST_AHI: begin
        take  = !busy_i;
        nxt   = ST_ALO;
        ld_hi = scl_rise && (bitcnt == CNT_W'(BYTE_W-1)) && take;
      end
      ST_ALO: begin
        take  = !busy_i;
        nxt   = ST_WR;
        ld_lo = scl_rise && (bitcnt == CNT_W'(BYTE_W-1)) && take;
      end
      ST_WR: begin
        take     = !busy_i;
        nxt      = ST_WR;
        adv      = scl_rise && (bitcnt == CNT_W'(BYTE_W-1)) && take;
        issue_wr = adv && !wp_i;
      end
      ST_MACK: begin
        take     = !sda_s && !busy_i;
        nxt      = ST_RD;
        issue_rd = scl_rise && take;
      end
      default: ;
    endcase
    if (start_det || stop_det) begin
      issue_rd = 1'b0;
      issue_wr = 1'b0;
      ld_hi    = 1'b0;
      ld_lo    = 1'b0;
      adv      = 1'b0;
    end
    ptr_inc = adv || issue_rd;
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      state     <= ST_IDLE;
      ret       <= ST_IDLE;
      bitcnt    <= '0;
      rx        <= '0;
      tx        <= '0;
      ack_ok    <= 1'b0;
      rd_pend   <= 1'b0;
      sda_oe    <= 1'b0;
      mem_en    <= 1'b0;
      mem_we    <= 1'b0;
      mem_addr  <= '0;
      mem_wdata <= '0;
    end else begin
      mem_en  <= 1'b0;
      mem_we  <= 1'b0;
      rd_pend <= mem_en && !mem_we;
      if (rd_pend) tx <= mem_rdata;
      if (issue_rd || issue_wr) begin
        mem_en    <= 1'b1;
        mem_we    <= issue_wr;
        mem_addr  <= ptr;
        mem_wdata <= byte_in;
      end
      if (start_det) begin
        state  <= ST_DEV;
        bitcnt <= '0;
        sda_oe <= 1'b0;
      end else if (stop_det) begin
        state  <= ST_IDLE;
        sda_oe <= 1'b0;
      end else begin
        case (state)
          ST_DEV, ST_AHI, ST_ALO, ST_WR: begin
            if (scl_rise) begin
              rx     <= byte_in[BYTE_W-2:0];
              bitcnt <= bitcnt + 1'b1;
              if (bitcnt == CNT_W'(BYTE_W-1)) begin
                state  <= ST_ACKWAIT;
                ack_ok <= take;
                ret    <= nxt;
              end
            end
          end
          ST_ACKWAIT: begin
            if (scl_fall) begin
              if (ack_ok) begin
                sda_oe <= 1'b1;
                state  <= ST_ACK;
              end else begin
                state  <= ST_IDLE;
              end
            end
          end
          ST_ACK: begin
            if (scl_fall) begin
              bitcnt <= '0;
              state  <= ret;
              sda_oe <= (ret == ST_RD) ? !tx[BYTE_W-1] : 1'b0;
            end
          end
          ST_RD: begin
            if (scl_fall) begin
              sda_oe <= !tx[BYTE_W-2];
              tx     <= {tx[BYTE_W-2:0], 1'b0};
            end else if (scl_rise) begin
              bitcnt <= bitcnt + 1'b1;
              if (bitcnt == CNT_W'(BYTE_W-1)) state <= ST_RREL;
            end
          end
          ST_RREL: begin
            if (scl_fall) begin
              sda_oe <= 1'b0;
              state  <= ST_MACK;
            end
          end
          ST_MACK: begin
            if (scl_rise) begin
              if (take) begin
                state <= ST_ACK;
                ret   <= ST_RD;
              end else begin
                state <= ST_IDLE;
              end
            end
          end
          default: state <= ST_IDLE;
        endcase
      end
    end
  end

  // R10: data line only moves while the clock line is low, or on START/STOP
  p_sda_hold_r10: assert property (@(posedge clk) disable iff (rst)
    ($past(scl_s) && !$past(start_det) && !$past(stop_det)) |-> $stable(sda_oe));

  // R3: array accesses come only at a bit boundary of the bus clock
  p_access_on_edge_r3: assert property (@(posedge clk) disable iff (rst)
    mem_en |-> $past(scl_rise));

  // R8: no array write while write protect was high
  p_wp_blocks_r8: assert property (@(posedge clk) disable iff (rst)
    (mem_en && mem_we) |-> !$past(wp_i));

  // R9: no array access while busy was high
  p_busy_blocks_r9: assert property (@(posedge clk) disable iff (rst)
    mem_en |-> !$past(busy_i));
endmodule

// File: tb/i2cmem_slave_bench.sv
module i2cmem_slave_bench;
  localparam int Q = 10;
  localparam logic [7:0] DEVW = 8'hAA;
  localparam logic [7:0] DEVR = 8'hAB;

  logic clk = 1'b0;
  logic rst = 1'b1;
  always #4 clk = ~clk;

  logic m_scl = 1'b1, m_sda = 1'b1;
  logic [2:0] strap = 3'b101;
  logic wp = 1'b0, busy = 1'b0;
  logic sda_oe, sda_line;
  logic mem_en, mem_we;
  logic [15:0] mem_addr;
  logic [7:0] mem_wdata, mem_rdata;

  assign sda_line = !(sda_oe || !m_sda);

  i2cmem_slave u_i2cmem_slave (
    .clk(clk), .rst(rst), .scl_i(m_scl), .sda_i(sda_line), .sda_oe(sda_oe),
    .strap_i(strap), .wp_i(wp), .busy_i(busy),
    .mem_en(mem_en), .mem_we(mem_we), .mem_addr(mem_addr),
    .mem_wdata(mem_wdata), .mem_rdata(mem_rdata)
  );

  int checks = 0, errors = 0;
  logic [7:0] sram [logic [15:0]];
  logic [7:0] ref_mem [logic [15:0]];
  logic [15:0] ref_ptr = 16'h0000;
  logic [23:0] wq [$];
  bit quiet = 1'b0;
  bit quiet_bad = 1'b0;

  function automatic logic [7:0] dflt(logic [15:0] a);
    return a[7:0] ^ a[15:8] ^ 8'h3C;
  endfunction

  function automatic logic [7:0] ref_rd(logic [15:0] a);
    return ref_mem.exists(a) ? ref_mem[a] : dflt(a);
  endfunction

  task automatic chk(bit ok, string tag, string what, int act, int exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s %s: actual %0h expected %0h", tag, what, act, exp);
    end
  endtask

  // SRAM model: one-cycle read latency
  always @(posedge clk) begin
    if (mem_en) begin
      if (mem_we) sram[mem_addr] = mem_wdata;
      else mem_rdata <= sram.exists(mem_addr) ? sram[mem_addr] : dflt(mem_addr);
    end
  end

  // per-clock comparison against the reference write stream and silence window
  always @(negedge clk) begin
    if (!rst && mem_en && mem_we) begin
      if (wq.size() == 0) chk(1'b0, "R8", "unexpected array write", int'(mem_addr), 0);
      else begin
        logic [23:0] e;
        e = wq.pop_front();
        chk({mem_addr, mem_wdata} == e, "R3", "array write addr/data",
            int'({mem_addr, mem_wdata}), int'(e));
      end
    end
    if (!rst && quiet && sda_oe) quiet_bad = 1'b1;
  end

  task automatic tick(int n);
    repeat (n) @(negedge clk);
  endtask

  task automatic bstart;
    m_sda = 1'b1; tick(Q);
    m_scl = 1'b1; tick(Q);
    m_sda = 1'b0; tick(Q);
    m_scl = 1'b0; tick(Q);
  endtask

  task automatic bstop;
    m_sda = 1'b0; tick(Q);
    m_scl = 1'b1; tick(Q);
    m_sda = 1'b1; tick(2*Q);
  endtask

  task automatic bbit(input bit b, output bit seen);
    m_sda = b; tick(Q);
    m_scl = 1'b1; tick(Q);
    seen = sda_line; tick(Q);
    m_scl = 1'b0; tick(Q);
  endtask

  task automatic sendb(input logic [7:0] b, output bit acked);
    bit s;
    for (int i = 7; i >= 0; i--) bbit(b[i], s);
    bbit(1'b1, s);
    acked = !s;
  endtask

  task automatic recvb(input bit ack, output logic [7:0] d);
    bit s;
    for (int i = 7; i >= 0; i--) begin
      bbit(1'b1, s);
      d[i] = s;
    end
    bbit(!ack, s);
  endtask

  task automatic quiet_begin;
    quiet = 1'b1; quiet_bad = 1'b0;
  endtask

  task automatic quiet_end(string tag);
    quiet = 1'b0;
    chk(!quiet_bad, tag, "data line driven while silent", int'(quiet_bad), 0);
  endtask

  task automatic wr_txn(input logic [15:0] addr, input logic [31:0] data, input int n,
                        input bit prot, input string tag);
    bit a;
    bstart;
    sendb(DEVW, a);        chk(a, "R3", "ack of write bus address", a, 1);
    sendb(addr[15:8], a);  chk(a, "R3", "ack of high address", a, 1);
    sendb(addr[7:0], a);   chk(a, "R3", "ack of low address", a, 1);
    ref_ptr = addr;
    for (int k = 0; k < n; k++) begin
      logic [7:0] d;
      d = data[31-8*k -: 8];
      if (!prot) begin
        wq.push_back({ref_ptr, d});
        ref_mem[ref_ptr] = d;
      end
      sendb(d, a);
      chk(a, tag, "ack of data byte", a, 1);
      ref_ptr = ref_ptr + 16'd1;
    end
    bstop;
    chk(wq.size() == 0, tag, "pending expected writes", wq.size(), 0);
  endtask

  task automatic rd_bytes(input int n, input string tag);
    logic [7:0] d;
    for (int k = 0; k < n; k++) begin
      recvb(k != n-1, d);
      chk(d == ref_rd(ref_ptr), tag, "read data", d, ref_rd(ref_ptr));
      ref_ptr = ref_ptr + 16'd1;
    end
    tick(2);
    chk(sda_oe == 1'b0, "R7", "line released after master NACK", sda_oe, 0);
    bstop;
  endtask

  task automatic rd_cur(input int n, input string tag);
    bit a;
    bstart;
    sendb(DEVR, a); chk(a, tag, "ack of read bus address", a, 1);
    rd_bytes(n, tag);
  endtask

  task automatic rd_rand(input logic [15:0] addr, input int n, input string tag);
    bit a;
    bstart;
    sendb(DEVW, a);       chk(a, "R6", "ack of bus address", a, 1);
    sendb(addr[15:8], a); chk(a, "R6", "ack of high address", a, 1);
    sendb(addr[7:0], a);  chk(a, "R6", "ack of low address", a, 1);
    ref_ptr = addr;
    bstart;
    sendb(DEVR, a);       chk(a, "R6", "ack after repeated START", a, 1);
    rd_bytes(n, tag);
  endtask

  task automatic finish_run;
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    errors++;
    $display("FAIL watchdog: actual timeout expected completion");
    finish_run();
  end

  initial begin
    bit a;
    tick(5);
    rst = 1'b0;
    tick(4);
    // R1: idle after reset
    chk(sda_oe == 1'b0, "R1", "data line enable after reset", sda_oe, 0);
    chk(mem_en == 1'b0, "R1", "memory strobe after reset", mem_en, 0);
    rd_cur(1, "R1");   // pointer starts at 0x0000

    // R3 write burst, R5 current read continues past it
    wr_txn(16'h1234, 32'hAABBCC00, 3, 1'b0, "R3");
    rd_cur(1, "R5");
    rd_rand(16'h1234, 3, "R6");
    rd_cur(2, "R7");

    // R2: wrong strap and wrong code stay silent, pointer untouched
    bstart;
    quiet_begin();
    sendb(8'hA6, a); chk(!a, "R2", "ack for wrong strap", a, 0);
    sendb(8'h12, a); chk(!a, "R2", "ack after mismatch", a, 0);
    bstop;
    quiet_end("R2");
    bstart;
    quiet_begin();
    sendb(8'hBA, a); chk(!a, "R2", "ack for wrong code", a, 0);
    bstop;
    quiet_end("R2");
    rd_cur(1, "R2");

    // R11: partial address then START leaves pointer as it was
    bstart;
    sendb(DEVW, a);  chk(a, "R11", "ack of bus address", a, 1);
    sendb(8'h55, a); chk(a, "R11", "ack of high address", a, 1);
    bstart;
    sendb(DEVR, a);  chk(a, "R11", "ack after abandoning write", a, 1);
    rd_bytes(1, "R11");

    // R8: protected write acknowledged but dropped, pointer still advances
    wp = 1'b1;
    wr_txn(16'h2000, 32'h11220000, 2, 1'b1, "R8");
    wp = 1'b0;
    rd_cur(1, "R8");
    rd_rand(16'h2000, 2, "R8");

    // R4: wrap from 0xFFFF to 0x0000
    wr_txn(16'hFFFF, 32'h77880000, 2, 1'b0, "R4");
    rd_rand(16'hFFFF, 3, "R4");

    // R9: busy blocks the bus address
    busy = 1'b1;
    bstart;
    quiet_begin();
    sendb(DEVW, a); chk(!a, "R9", "ack while busy", a, 0);
    bstop;
    quiet_end("R9");
    busy = 1'b0;

    // R9: busy during a data byte, address phase already committed
    bstart;
    sendb(DEVW, a);  chk(a, "R9", "ack of bus address", a, 1);
    sendb(8'h30, a); chk(a, "R9", "ack of high address", a, 1);
    sendb(8'h00, a); chk(a, "R9", "ack of low address", a, 1);
    ref_ptr = 16'h3000;
    busy = 1'b1;
    sendb(8'h5A, a); chk(!a, "R9", "ack of data while busy", a, 0);
    busy = 1'b0;
    bstop;
    rd_cur(1, "R9");
    chk(wq.size() == 0, "R9", "pending expected writes", wq.size(), 0);

    tick(20);
    finish_run();
  end
endmodule